// File: doc/BRIEF.md
# I2C Byte FIFO Pair with Threshold Flags

This block buffers bytes in both directions between a register-mapped host and an I2C byte engine. The host pushes outgoing bytes into a transmit queue that the engine drains. The engine pushes received bytes into a receive queue that the host drains. Both queues are first-word-fall-through: the head byte is visible on the read port before it is popped, and popping an empty queue returns zero.

Each queue has a programmable threshold. Values written above the legal ceiling are clamped to the ceiling. Each queue also has a flush request. Once requested, a flush drains the queue by one entry per cycle and reports busy until the queue is empty again. A set of raw status flags, at fixed bit positions, goes to a downstream interrupt unit. The transmit overrun flag is sticky: it is set when the host pushes into a full transmit queue.

Top module: `i2c_fifo_pair`

## Requirements
- R1: Each queue returns bytes in the order they were pushed. After reset both levels read 0 and `raw_flags` reads 7'b0010011.
- R2: `raw_flags` bit positions are fixed as follows:
  - bit 0: tx empty
  - bit 1: tx nearly empty
  - bit 2: tx full
  - bit 3: tx overrun
  - bit 4: rx empty
  - bit 5: rx nearly full
  - bit 6: rx full
- R3: Bit 1 is high exactly when the tx level is less than or equal to the tx threshold.
- R4: Bit 5 is high exactly when the rx level is greater than or equal to the rx threshold.
- R5: A queue is full at DEPTH entries. A push into a full queue is discarded: the level and the stored bytes do not change.
- R6: Bit 3 goes high in the cycle after a host push into a full tx queue. It stays high until a tx flush is requested, which clears it in the next cycle. An rx overflow never sets bit 3.
- R7: Popping an empty queue gives read data 0 and leaves the level at 0.
- R8: A flush request raises that queue's busy output in the next cycle. The queue then loses one entry per cycle, and busy drops in the cycle after the level reaches 0. For N entries, busy is high for N+1 cycles, so 1 cycle for an empty queue.
- R9: While a flush is requested or busy, pushes and pops on that queue are ignored.
- R10: A threshold write larger than DEPTH/2-1 stores DEPTH/2-1 (7 for DEPTH 16). After reset the tx threshold is 1 and the rx threshold is min(8, DEPTH/2-1).
- R11: A push and a pop on the same queue in the same cycle, when the queue is neither empty nor full, both take effect and leave the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_tx_push | input | 1 | Host writes a byte to the tx queue |
| host_tx_data | input | 8 | Byte written by the host |
| eng_tx_pop | input | 1 | Engine takes the tx head byte |
| eng_tx_data | output | 8 | tx head byte, 0 when empty |
| eng_rx_push | input | 1 | Engine stores a received byte |
| eng_rx_data | input | 8 | Received byte |
| host_rx_pop | input | 1 | Host takes the rx head byte |
| host_rx_data | output | 8 | rx head byte, 0 when empty |
| thr_tx_we | input | 1 | Write the tx threshold |
| thr_rx_we | input | 1 | Write the rx threshold |
| thr_wdata | input | 8 | Threshold write value |
| tx_thr_q | output | 8 | Stored tx threshold |
| rx_thr_q | output | 8 | Stored rx threshold |
| flush_tx_req | input | 1 | Start a tx flush |
| flush_rx_req | input | 1 | Start an rx flush |
| flush_tx_busy | output | 1 | tx flush in progress, self-clearing |
| flush_rx_busy | output | 1 | rx flush in progress, self-clearing |
| tx_level | output | $clog2(DEPTH+1) | tx occupancy |
| rx_level | output | $clog2(DEPTH+1) | rx occupancy |
| raw_flags | output | 7 | Raw status flags, bit map in R2 |

## Verification
A push and a pop can land on the same queue in the same cycle. The bench provokes this on the rx queue while it sits exactly at its threshold. It then judges that the level and the nearly-full flag are unchanged, and that the bytes come out in order. A flush can also meet pushes and pops held active for its whole duration. The bench judges that case by the exact busy duration and by a final level of zero.

// File: rtl/i2c_fifo_pkg.sv
package i2c_fifo_pkg;
   localparam int FLAG_W       = 7;
   localparam int FLG_TX_EMPTY = 0;
   localparam int FLG_TX_NEMPT = 1;
   localparam int FLG_TX_FULL  = 2;
   localparam int FLG_TX_OVR   = 3;
   localparam int FLG_RX_EMPTY = 4;
   localparam int FLG_RX_NFULL = 5;
   localparam int FLG_RX_FULL  = 6;
   localparam int DIR_TX = 0;
   localparam int DIR_RX = 1;
   localparam int N_DIR  = 2;
endpackage

// File: rtl/i2c_thr_reg.sv
module i2c_thr_reg #(
   parameter int THR_W = 3,
   parameter int MAXV  = 7,
   parameter int RSTV  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [7:0]       wdata,
   output logic [THR_W-1:0] thr
);
   logic [THR_W-1:0] clamped;

   always_comb begin
      if (int'(wdata) > MAXV) clamped = THR_W'(MAXV);
      else                    clamped = wdata[THR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  thr <= THR_W'(RSTV);
      else if (we) thr <= clamped;
   end

   assert_thr_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      int'(thr) <= MAXV);
   assert_thr_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      we && int'(wdata) > MAXV |=> int'(thr) == MAXV);
endmodule

// File: rtl/i2c_fifo_buf.sv
module i2c_fifo_buf #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pop,
   output logic [DATA_W-1:0] pop_data,
   input  logic              flush_req,
   output logic              busy,
   output logic [LVL_W-1:0]  level,
   output logic              empty,
   output logic              full,
   output logic              push_drop
);
   localparam int PTR_W = $clog2(DEPTH);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [LVL_W-1:0]  level_q;
   logic              busy_q;
   logic              gated, do_push, do_pop, drain, do_adv;

   assign empty    = (level_q == '0);
   assign full     = (level_q == LVL_W'(DEPTH));
   assign gated    = busy_q | flush_req;
   assign do_push  = push & ~gated & ~full;
   assign do_pop   = pop & ~gated & ~empty;
   assign drain    = busy_q & ~empty;
   assign do_adv   = do_pop | drain;
   assign push_drop = push & ~gated & full;
   assign pop_data = empty ? '0 : mem_q[rd_ptr];
   assign level    = level_q;
   assign busy     = busy_q;

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         level_q <= '0;
         busy_q  <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_adv)  rd_ptr <= rd_ptr + 1'b1;
         level_q <= level_q + LVL_W'(do_push) - LVL_W'(do_adv);
         busy_q  <= flush_req | (busy_q & ~empty);
      end
   end

   assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(level_q) <= DEPTH);
   assert_full_push_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
      push && full && !pop && !gated |=> level_q == $past(level_q));
   assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop && empty && !push |=> level_q == '0);
   assert_flush_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> busy_q);
   assert_flush_done_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> level_q == '0);
   assert_flush_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |=> level_q <= $past(level_q));
   assert_push_pop_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
      push && pop && !empty && !full && !gated |=> level_q == $past(level_q));
endmodule

// File: rtl/i2c_fifo_pair.sv
module i2c_fifo_pair
   import i2c_fifo_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   parameter int TX_THR_RST = 1,
   parameter int RX_THR_RST = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         host_tx_push,
   input  logic [DATA_W-1:0]            host_tx_data,
   input  logic                         eng_tx_pop,
   output logic [DATA_W-1:0]            eng_tx_data,
   input  logic                         eng_rx_push,
   input  logic [DATA_W-1:0]            eng_rx_data,
   input  logic                         host_rx_pop,
   output logic [DATA_W-1:0]            host_rx_data,
   input  logic                         thr_tx_we,
   input  logic                         thr_rx_we,
   input  logic [7:0]                   thr_wdata,
   output logic [7:0]                   tx_thr_q,
   output logic [7:0]                   rx_thr_q,
   input  logic                         flush_tx_req,
   input  logic                         flush_rx_req,
   output logic                         flush_tx_busy,
   output logic                         flush_rx_busy,
   output logic [$clog2(DEPTH+1)-1:0]   tx_level,
   output logic [$clog2(DEPTH+1)-1:0]   rx_level,
   output logic [FLAG_W-1:0]            raw_flags
);
   localparam int LVL_W   = $clog2(DEPTH + 1);
   localparam int THR_MAX = DEPTH / 2 - 1;
   localparam int THR_W   = $clog2(DEPTH / 2);
   localparam int TX_RST  = (TX_THR_RST > THR_MAX) ? THR_MAX : TX_THR_RST;
   localparam int RX_RST  = (RX_THR_RST > THR_MAX) ? THR_MAX : RX_THR_RST;

   generate
      if (DEPTH != 16 && DEPTH != 32) begin : g_bad_depth
         $error("i2c_fifo_pair: DEPTH must be 16 or 32");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("i2c_fifo_pair: DATA_W must be positive");
      end
   endgenerate

   logic              push_v  [N_DIR];
   logic [DATA_W-1:0] wdat_v  [N_DIR];
   logic              pop_v   [N_DIR];
   logic [DATA_W-1:0] rdat_v  [N_DIR];
   logic              flush_v [N_DIR];
   logic              busy_v  [N_DIR];
   logic [LVL_W-1:0]  lvl_v   [N_DIR];
   logic              empty_v [N_DIR];
   logic              full_v  [N_DIR];
   logic              drop_v  [N_DIR];

   assign push_v[DIR_TX]  = host_tx_push;
   assign wdat_v[DIR_TX]  = host_tx_data;
   assign pop_v[DIR_TX]   = eng_tx_pop;
   assign flush_v[DIR_TX] = flush_tx_req;
   assign push_v[DIR_RX]  = eng_rx_push;
   assign wdat_v[DIR_RX]  = eng_rx_data;
   assign pop_v[DIR_RX]   = host_rx_pop;
   assign flush_v[DIR_RX] = flush_rx_req;

   for (genvar d = 0; d < N_DIR; d++) begin : g_dir
      i2c_fifo_buf #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) u_buf (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (push_v[d]),
         .push_data (wdat_v[d]),
         .pop       (pop_v[d]),
         .pop_data  (rdat_v[d]),
         .flush_req (flush_v[d]),
         .busy      (busy_v[d]),
         .level     (lvl_v[d]),
         .empty     (empty_v[d]),
         .full      (full_v[d]),
         .push_drop (drop_v[d])
      );
   end

   logic [THR_W-1:0] tx_thr, rx_thr;

   i2c_thr_reg #(.THR_W(THR_W), .MAXV(THR_MAX), .RSTV(TX_RST)) u_tx_thr (
      .clk(clk), .rst_n(rst_n), .we(thr_tx_we), .wdata(thr_wdata), .thr(tx_thr));
   i2c_thr_reg #(.THR_W(THR_W), .MAXV(THR_MAX), .RSTV(RX_RST)) u_rx_thr (
      .clk(clk), .rst_n(rst_n), .we(thr_rx_we), .wdata(thr_wdata), .thr(rx_thr));

   logic ovr_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ovr_q <= 1'b0;
      else if (flush_tx_req)      ovr_q <= 1'b0;
      else if (drop_v[DIR_TX])    ovr_q <= 1'b1;
   end

   assign eng_tx_data   = rdat_v[DIR_TX];
   assign host_rx_data  = rdat_v[DIR_RX];
   assign flush_tx_busy = busy_v[DIR_TX];
   assign flush_rx_busy = busy_v[DIR_RX];
   assign tx_level      = lvl_v[DIR_TX];
   assign rx_level      = lvl_v[DIR_RX];
   assign tx_thr_q      = 8'(tx_thr);
   assign rx_thr_q      = 8'(rx_thr);

   always_comb begin
      raw_flags               = '0;
      raw_flags[FLG_TX_EMPTY] = empty_v[DIR_TX];
      raw_flags[FLG_TX_NEMPT] = lvl_v[DIR_TX] <= LVL_W'(tx_thr);
      raw_flags[FLG_TX_FULL]  = full_v[DIR_TX];
      raw_flags[FLG_TX_OVR]   = ovr_q;
      raw_flags[FLG_RX_EMPTY] = empty_v[DIR_RX];
      raw_flags[FLG_RX_NFULL] = lvl_v[DIR_RX] >= LVL_W'(rx_thr);
      raw_flags[FLG_RX_FULL]  = full_v[DIR_RX];
   end

   assert_overrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      drop_v[DIR_TX] |=> raw_flags[FLG_TX_OVR]);
   assert_overrun_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      flush_tx_req |=> !raw_flags[FLG_TX_OVR]);
   assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      raw_flags[FLG_TX_OVR] && !flush_tx_req |=> raw_flags[FLG_TX_OVR]);
   assert_flag_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(raw_flags[FLG_TX_EMPTY] && raw_flags[FLG_TX_FULL]) &&
      !(raw_flags[FLG_RX_EMPTY] && raw_flags[FLG_RX_FULL]));
endmodule

// File: tb/i2c_fifo_pair_tb.sv
module i2c_fifo_pair_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;
   localparam int LVL_W = $clog2(DEPTH + 1);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_tx_push = 0, eng_tx_pop = 0, eng_rx_push = 0, host_rx_pop = 0;
   logic [7:0] host_tx_data = 0, eng_rx_data = 0, thr_wdata = 0;
   logic thr_tx_we = 0, thr_rx_we = 0, flush_tx_req = 0, flush_rx_req = 0;
   logic [7:0] eng_tx_data, host_rx_data, tx_thr_q, rx_thr_q;
   logic flush_tx_busy, flush_rx_busy;
   logic [LVL_W-1:0] tx_level, rx_level;
   logic [6:0] raw_flags;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_fifo_pair #(.DEPTH(DEPTH)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
      .thr_tx_we(thr_tx_we), .thr_rx_we(thr_rx_we), .thr_wdata(thr_wdata),
      .tx_thr_q(tx_thr_q), .rx_thr_q(rx_thr_q),
      .flush_tx_req(flush_tx_req), .flush_rx_req(flush_rx_req),
      .flush_tx_busy(flush_tx_busy), .flush_rx_busy(flush_rx_busy),
      .tx_level(tx_level), .rx_level(rx_level), .raw_flags(raw_flags));

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic tx_push(input logic [7:0] d);
      host_tx_push = 1; host_tx_data = d; step(); host_tx_push = 0;
   endtask

   task automatic rx_push(input logic [7:0] d);
      eng_rx_push = 1; eng_rx_data = d; step(); eng_rx_push = 0;
   endtask

   task automatic flush_run(input bit rx, output int cycles);
      if (rx) flush_rx_req = 1; else flush_tx_req = 1;
      step();
      flush_rx_req = 0; flush_tx_req = 0;
      cycles = 0;
      while ((rx ? flush_rx_busy : flush_tx_busy) && cycles < 100) begin
         cycles++;
         step();
      end
      host_tx_push = 0; eng_rx_push = 0; host_rx_pop = 0; eng_tx_pop = 0;
   endtask

   task automatic t_reset();
      check("R1 reset tx_level", tx_level, 0);
      check("R1 reset rx_level", rx_level, 0);
      check("R1 R2 reset flags", raw_flags, 7'b0010011);
      check("R10 reset tx thr", tx_thr_q, 1);
      check("R10 reset rx thr", rx_thr_q, 7);
   endtask

   task automatic t_order();
      tx_push(8'hA1); tx_push(8'hB2); tx_push(8'hC3);
      check("R1 tx level 3", tx_level, 3);
      check("R3 nearly empty low at 3>1", raw_flags[1], 0);
      check("R1 head A1", eng_tx_data, 8'hA1);
      eng_tx_pop = 1; step();
      check("R1 head B2", eng_tx_data, 8'hB2);
      step();
      check("R1 head C3", eng_tx_data, 8'hC3);
      check("R3 nearly empty high at 1", raw_flags[1], 1);
      step(); eng_tx_pop = 0;
      check("R1 tx drained", tx_level, 0);
   endtask

   task automatic t_tx_thr();
      int c;
      thr_tx_we = 1; thr_wdata = 4; step(); thr_tx_we = 0;
      check("R10 tx thr 4", tx_thr_q, 4);
      for (int i = 0; i < 4; i++) tx_push(8'(i));
      check("R3 nearly empty at level 4 thr 4", raw_flags[1], 1);
      tx_push(8'h55);
      check("R3 nearly empty at level 5 thr 4", raw_flags[1], 0);
      flush_run(0, c);
      check("R8 flush of 5 busy cycles", c, 6);
   endtask

   task automatic t_clamp();
      thr_rx_we = 1; thr_wdata = 200; step();
      check("R10 clamp 200", rx_thr_q, 7);
      thr_wdata = 8; step();
      check("R10 clamp 8", rx_thr_q, 7);
      thr_wdata = 3; step(); thr_rx_we = 0;
      check("R10 rx thr 3", rx_thr_q, 3);
   endtask

   task automatic t_rx_nf_simul();
      rx_push(8'h10); rx_push(8'h20);
      check("R4 nearly full low at 2", raw_flags[5], 0);
      rx_push(8'h30);
      check("R4 nearly full high at 3", raw_flags[5], 1);
      check("R2 rx empty low", raw_flags[4], 0);
      eng_rx_push = 1; eng_rx_data = 8'h40; host_rx_pop = 1;
      check("R11 head before swap", host_rx_data, 8'h10);
      step(); eng_rx_push = 0; host_rx_pop = 0;
      check("R11 level unchanged", rx_level, 3);
      check("R11 nearly full held", raw_flags[5], 1);
      host_rx_pop = 1;
      check("R11 order 20", host_rx_data, 8'h20); step();
      check("R11 order 30", host_rx_data, 8'h30); step();
      check("R11 order 40", host_rx_data, 8'h40); step();
      host_rx_pop = 0;
      check("R1 rx drained", rx_level, 0);
   endtask

   task automatic t_full_overrun();
      int c;
      for (int i = 0; i < DEPTH; i++) tx_push(8'(i*3+1));
      check("R5 tx full flag", raw_flags[2], 1);
      check("R6 no overrun yet", raw_flags[3], 0);
      tx_push(8'hEE);
      check("R5 level held", tx_level, DEPTH);
      check("R6 overrun set", raw_flags[3], 1);
      eng_tx_pop = 1;
      for (int i = 0; i < DEPTH; i++) begin
         check("R5 content unchanged", eng_tx_data, (i*3+1) & 8'hFF);
         step();
      end
      eng_tx_pop = 0;
      check("R6 overrun sticky", raw_flags[3], 1);
      flush_run(0, c);
      check("R8 empty flush 1 cycle", c, 1);
      check("R6 overrun cleared by flush", raw_flags[3], 0);
   endtask

   task automatic t_rx_full();
      int c;
      for (int i = 0; i < DEPTH + 1; i++) rx_push(8'(i));
      check("R5 rx level capped", rx_level, DEPTH);
      check("R5 rx full flag", raw_flags[6], 1);
      check("R6 rx overflow not overrun", raw_flags[3], 0);
      flush_run(1, c);
      check("R8 rx flush of 16", c, DEPTH + 1);
   endtask

   task automatic t_empty_read();
      host_rx_pop = 1;
      check("R7 empty read zero", host_rx_data, 0);
      step(); host_rx_pop = 0;
      check("R7 level stays 0", rx_level, 0);
   endtask

   task automatic t_flush_block();
      int c;
      tx_push(8'h01); tx_push(8'h02); tx_push(8'h03);
      host_tx_push = 1; host_tx_data = 8'h77;
      flush_run(0, c);
      check("R8 flush of 3 busy cycles", c, 4);
      check("R9 pushes ignored during tx flush", tx_level, 0);
      rx_push(8'h0A); rx_push(8'h0B);
      eng_rx_push = 1; eng_rx_data = 8'h66;
      flush_run(1, c);
      check("R8 rx flush of 2", c, 3);
      check("R9 pushes ignored during rx flush", rx_level, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_order();
      t_tx_thr();
      t_clamp();
      t_rx_nf_simul();
      t_full_overrun();
      t_rx_full();
      t_empty_read();
      t_flush_block();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule